// File: doc/BRIEF.md
# Coprocessor Instruction Decode Handshake

This block is the coprocessor side of a CPU's auxiliary instruction port. The CPU-side controller offers an instruction word and two operands with a one-cycle valid strobe. The block latches the word and the operands in that cycle. It then decodes the word for one cycle or, for the complex class, for several cycles with a busy flag raised. It acknowledges the instruction together with a set of attribute flags. These flags tell the CPU how the instruction uses registers, the condition register and memory.

After the acknowledge, the block runs the operation. Add and xor finish in one cycle. Multiply-accumulate takes several cycles and uses an internal accumulator. Memory-type and autonomous operations only signal that the block is free again. Completion is a single-cycle done pulse, and a 32-bit result is valid in that cycle. A sleep-not-ready flag stays high while an accepted instruction is still in decode or execution. Words outside the block's opcode space are dropped without an acknowledge.

Top module: `aux_cop_unit`

Instruction word layout: bits [31:26] primary opcode, bits [25:23] condition-field select, bits [22:3] reserved (must be zero), bits [2:0] sub-operation.

## Requirements
- R1: While reset is active and in the first cycle after it, instr_ack_o, decode_busy_o, done_o and sleep_nrdy_o are low, result_o is zero and every attribute output is zero.
- R2: When the block is idle, it samples instr_word_i, op_a_i and op_b_i only in the cycle where instr_valid_i is high. Changes to these inputs in later cycles do not affect the decode or the result.
- R3: Simple sub-operations (0 add, 1 xor, 3 store-halfword, 4 load-byte-update) raise instr_ack_o in the cycle right after the valid cycle, and decode_busy_o stays low throughout.
- R4: Complex sub-operations (2 multiply-accumulate, 5 clear-accumulator) hold decode_busy_o high for COMPLEX_LAT-1 cycles (default 2) after the valid cycle. instr_ack_o rises in the first cycle with decode_busy_o low.
- R5: The attribute outputs are zero except in the acknowledge cycle. In that cycle they are: add = gpr_wr, need_ra, need_rb, ovf_en, carry_en; xor = gpr_wr, need_ra, need_rb, cr_en; multiply-accumulate = gpr_wr, need_ra, need_rb; store-halfword = store, xfer_half, word_align, need_ra, need_rb, priv; load-byte-update = load, xfer_byte, ea_update, need_ra, gpr_wr; clear-accumulator = priv. load_o and store_o are never high together.
- R6: For xor, cr_field_o equals word bits [25:23] in the acknowledge cycle. It is zero for every other sub-operation.
- R7: A word whose primary opcode is not OPC_SPACE (default 6'h04), whose sub-operation is 6 or 7, or whose reserved bits are not zero is never acknowledged. No busy and no done are raised for it. Sleep-not-ready is high only in the cycle after the valid cycle, and a new valid in the cycle after that is accepted.
- R8: For add and xor, done_o pulses in the cycle after the acknowledge. In that cycle result_o is a+b (mod 2^32) or a^b. result_o is zero in every cycle without done_o.
- R9: Multiply-accumulate raises done_o MAC_CYCLES (default 4) cycles after the acknowledge. The result is the accumulator plus the low 32 bits of a*b, and that value becomes the new accumulator, which starts at zero.
- R10: Store-halfword, load-byte-update and clear-accumulator raise done_o in the cycle after the acknowledge with result_o zero. Clear-accumulator sets the accumulator to zero.
- R11: sleep_nrdy_o is high from the cycle after an accepted valid through the done cycle inclusive, and low in the cycle after done.
- R12: instr_valid_i is ignored in every cycle from the one after an accepted valid through the done cycle. A valid in the cycle after done is accepted.
- R13: done_o is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Coprocessor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid_i | input | 1 | Instruction offered this cycle |
| instr_word_i | input | 32 | Instruction word |
| op_a_i | input | 32 | First operand, sampled with the word |
| op_b_i | input | 32 | Second operand, sampled with the word |
| decode_busy_o | output | 1 | Decode still in progress |
| instr_ack_o | output | 1 | Instruction accepted; attributes valid |
| gpr_wr_o | output | 1 | Writes a general-purpose register |
| need_ra_o | output | 1 | Needs the Ra operand |
| need_rb_o | output | 1 | Needs the Rb operand |
| priv_o | output | 1 | Privileged instruction |
| ovf_en_o | output | 1 | Returns overflow status |
| carry_en_o | output | 1 | Returns carry status |
| cr_en_o | output | 1 | Updates a condition-register field |
| cr_field_o | output | 3 | Condition-register field index |
| load_o | output | 1 | Load instruction |
| store_o | output | 1 | Store instruction |
| ea_update_o | output | 1 | Update Ra with effective address |
| xfer_byte_o | output | 1 | Byte transfer |
| xfer_half_o | output | 1 | Halfword transfer |
| word_align_o | output | 1 | Forced word alignment |
| result_o | output | 32 | Execution result, valid with done |
| done_o | output | 1 | Completion pulse |
| sleep_nrdy_o | output | 1 | Instruction still in flight |

## Verification
The bench changes the word and operand inputs right after the valid cycle. A design that kept sampling them would return a result computed from the changed values. It counts busy cycles for the complex class: an acknowledge one cycle early, or busy still high in the acknowledge cycle, shows up directly. It offers a new valid while decode is running and again inside the done cycle. A design that accepted either would keep sleep-not-ready high afterwards or return the wrong result. It also sends words with a foreign opcode, a reserved sub-operation and a set reserved bit. It then runs a chain of multiply-accumulates, including a clear and a wrapping product, so a design that lost or failed to clear the accumulator returns visibly wrong sums.

// File: rtl/aux_cop_pkg.sv
package aux_cop_pkg;

    localparam int DATA_W = 32;

    typedef enum logic [2:0] {
        SUB_ADD    = 3'd0,
        SUB_XOR    = 3'd1,
        SUB_MAC    = 3'd2,
        SUB_STH    = 3'd3,
        SUB_LDBU   = 3'd4,
        SUB_CLRACC = 3'd5,
        SUB_RSV6   = 3'd6,
        SUB_RSV7   = 3'd7
    } sub_op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DECODE = 2'd1,
        ST_EXEC   = 2'd2
    } hs_state_e;

    typedef struct packed {
        logic       gpr_wr;
        logic       need_ra;
        logic       need_rb;
        logic       priv;
        logic       ovf_en;
        logic       carry_en;
        logic       cr_en;
        logic [2:0] cr_field;
        logic       load;
        logic       store;
        logic       ea_update;
        logic       xfer_byte;
        logic       xfer_half;
        logic       word_align;
    } cop_attr_t;

    function automatic logic is_complex(input sub_op_e op);
        return (op == SUB_MAC) || (op == SUB_CLRACC);
    endfunction

endpackage

// File: rtl/aux_cop_decoder.sv
module aux_cop_decoder
    import aux_cop_pkg::*;
#(
    parameter logic [5:0] OPC_SPACE   = 6'h04,
    parameter int         COMPLEX_LAT = 3,
    parameter int         CW          = $clog2(COMPLEX_LAT + 1)
) (
    input  logic [DATA_W-1:0] instr_i,
    output logic              match_o,
    output logic [CW-1:0]     last_cnt_o,
    output sub_op_e           op_o,
    output cop_attr_t         attr_o
);

    logic [5:0]  prim;
    logic [2:0]  crf;
    logic [19:0] rsvd;

    assign prim = instr_i[31:26];
    assign crf  = instr_i[25:23];
    assign rsvd = instr_i[22:3];

    always_comb begin
        op_o    = sub_op_e'(instr_i[2:0]);
        attr_o  = '0;
        match_o = (prim == OPC_SPACE) && (rsvd == '0);
        unique case (op_o)
            SUB_ADD: begin
                attr_o.gpr_wr   = 1'b1;
                attr_o.need_ra  = 1'b1;
                attr_o.need_rb  = 1'b1;
                attr_o.ovf_en   = 1'b1;
                attr_o.carry_en = 1'b1;
            end
            SUB_XOR: begin
                attr_o.gpr_wr   = 1'b1;
                attr_o.need_ra  = 1'b1;
                attr_o.need_rb  = 1'b1;
                attr_o.cr_en    = 1'b1;
                attr_o.cr_field = crf;
            end
            SUB_MAC: begin
                attr_o.gpr_wr  = 1'b1;
                attr_o.need_ra = 1'b1;
                attr_o.need_rb = 1'b1;
            end
            SUB_STH: begin
                attr_o.store      = 1'b1;
                attr_o.xfer_half  = 1'b1;
                attr_o.word_align = 1'b1;
                attr_o.need_ra    = 1'b1;
                attr_o.need_rb    = 1'b1;
                attr_o.priv       = 1'b1;
            end
            SUB_LDBU: begin
                attr_o.load      = 1'b1;
                attr_o.xfer_byte = 1'b1;
                attr_o.ea_update = 1'b1;
                attr_o.need_ra   = 1'b1;
                attr_o.gpr_wr    = 1'b1;
            end
            SUB_CLRACC: begin
                attr_o.priv = 1'b1;
            end
            default: begin
                match_o = 1'b0;
            end
        endcase
        last_cnt_o = is_complex(op_o) ? CW'(COMPLEX_LAT - 1) : '0;
    end

endmodule

// File: rtl/aux_cop_exec.sv
module aux_cop_exec
    import aux_cop_pkg::*;
#(
    parameter int MAC_CYCLES = 4,
    parameter int RW         = $clog2(MAC_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  sub_op_e           op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic              done_o,
    output logic [DATA_W-1:0] result_o
);

    typedef struct packed {
        logic              run;
        logic [RW-1:0]     rem;
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] b;
        logic [DATA_W-1:0] acc;
        logic              done;
        logic [DATA_W-1:0] result;
    } ex_t;

    ex_t ex_d, ex_q;
    logic [DATA_W-1:0] mac_now, mac_run;

    assign mac_now = ex_q.acc + a_i * b_i;
    assign mac_run = ex_q.acc + ex_q.a * ex_q.b;

    always_comb begin
        ex_d        = ex_q;
        ex_d.done   = 1'b0;
        ex_d.result = '0;
        if (start_i) begin
            ex_d.a = a_i;
            ex_d.b = b_i;
            unique case (op_i)
                SUB_ADD: begin
                    ex_d.done   = 1'b1;
                    ex_d.result = a_i + b_i;
                end
                SUB_XOR: begin
                    ex_d.done   = 1'b1;
                    ex_d.result = a_i ^ b_i;
                end
                SUB_MAC: begin
                    if (MAC_CYCLES <= 1) begin
                        ex_d.acc    = mac_now;
                        ex_d.done   = 1'b1;
                        ex_d.result = mac_now;
                    end else begin
                        ex_d.run = 1'b1;
                        ex_d.rem = RW'(MAC_CYCLES - 1);
                    end
                end
                SUB_CLRACC: begin
                    ex_d.acc  = '0;
                    ex_d.done = 1'b1;
                end
                default: begin
                    ex_d.done = 1'b1;
                end
            endcase
        end else if (ex_q.run) begin
            if (ex_q.rem == RW'(1)) begin
                ex_d.run    = 1'b0;
                ex_d.rem    = '0;
                ex_d.acc    = mac_run;
                ex_d.done   = 1'b1;
                ex_d.result = mac_run;
            end else begin
                ex_d.rem = ex_q.rem - RW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ex_q <= '0;
        end else begin
            ex_q <= ex_d;
        end
    end

    assign done_o   = ex_q.done;
    assign result_o = ex_q.result;

    AST_START_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !ex_q.run) else $error("start while running"); // R12
    AST_RESULT_ONLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> (result_o == '0)) else $error("result without done"); // R8

endmodule

// File: rtl/aux_cop_unit.sv
module aux_cop_unit
    import aux_cop_pkg::*;
#(
    parameter logic [5:0] OPC_SPACE   = 6'h04,
    parameter int         COMPLEX_LAT = 3,
    parameter int         MAC_CYCLES  = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        instr_valid_i,
    input  logic [31:0] instr_word_i,
    input  logic [31:0] op_a_i,
    input  logic [31:0] op_b_i,
    output logic        decode_busy_o,
    output logic        instr_ack_o,
    output logic        gpr_wr_o,
    output logic        need_ra_o,
    output logic        need_rb_o,
    output logic        priv_o,
    output logic        ovf_en_o,
    output logic        carry_en_o,
    output logic        cr_en_o,
    output logic [2:0]  cr_field_o,
    output logic        load_o,
    output logic        store_o,
    output logic        ea_update_o,
    output logic        xfer_byte_o,
    output logic        xfer_half_o,
    output logic        word_align_o,
    output logic [31:0] result_o,
    output logic        done_o,
    output logic        sleep_nrdy_o
);

    localparam int CW = $clog2(COMPLEX_LAT + 1);

    typedef struct packed {
        hs_state_e         state;
        logic [CW-1:0]     cnt;
        logic [DATA_W-1:0] instr;
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] b;
    } hs_t;

    hs_t hs_d, hs_q;

    logic          dec_match;
    logic [CW-1:0] dec_last;
    sub_op_e       dec_op;
    cop_attr_t     dec_attr;
    cop_attr_t     attr_out;
    logic          ack_c, busy_c, start_c;
    logic          ex_done;

    aux_cop_decoder #(
        .OPC_SPACE  (OPC_SPACE),
        .COMPLEX_LAT(COMPLEX_LAT),
        .CW         (CW)
    ) u_dec (
        .instr_i   (hs_q.instr),
        .match_o   (dec_match),
        .last_cnt_o(dec_last),
        .op_o      (dec_op),
        .attr_o    (dec_attr)
    );

    aux_cop_exec #(
        .MAC_CYCLES(MAC_CYCLES)
    ) u_exec (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_c),
        .op_i    (dec_op),
        .a_i     (hs_q.a),
        .b_i     (hs_q.b),
        .done_o  (ex_done),
        .result_o(result_o)
    );

    always_comb begin
        hs_d    = hs_q;
        ack_c   = 1'b0;
        busy_c  = 1'b0;
        start_c = 1'b0;
        unique case (hs_q.state)
            ST_IDLE: begin
                if (instr_valid_i) begin
                    hs_d.instr = instr_word_i;
                    hs_d.a     = op_a_i;
                    hs_d.b     = op_b_i;
                    hs_d.cnt   = '0;
                    hs_d.state = ST_DECODE;
                end
            end
            ST_DECODE: begin
                if (!dec_match) begin
                    hs_d.state = ST_IDLE;
                end else if (hs_q.cnt == dec_last) begin
                    ack_c      = 1'b1;
                    start_c    = 1'b1;
                    hs_d.state = ST_EXEC;
                end else begin
                    busy_c   = 1'b1;
                    hs_d.cnt = hs_q.cnt + CW'(1);
                end
            end
            ST_EXEC: begin
                if (ex_done) begin
                    hs_d.state = ST_IDLE;
                end
            end
            default: begin
                hs_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_q <= '{state: ST_IDLE, default: '0};
        end else begin
            hs_q <= hs_d;
        end
    end

    assign attr_out      = ack_c ? dec_attr : '0;
    assign instr_ack_o   = ack_c;
    assign decode_busy_o = busy_c;
    assign done_o        = ex_done;
    assign sleep_nrdy_o  = (hs_q.state != ST_IDLE);

    assign gpr_wr_o     = attr_out.gpr_wr;
    assign need_ra_o    = attr_out.need_ra;
    assign need_rb_o    = attr_out.need_rb;
    assign priv_o       = attr_out.priv;
    assign ovf_en_o     = attr_out.ovf_en;
    assign carry_en_o   = attr_out.carry_en;
    assign cr_en_o      = attr_out.cr_en;
    assign cr_field_o   = attr_out.cr_field;
    assign load_o       = attr_out.load;
    assign store_o      = attr_out.store;
    assign ea_update_o  = attr_out.ea_update;
    assign xfer_byte_o  = attr_out.xfer_byte;
    assign xfer_half_o  = attr_out.xfer_half;
    assign word_align_o = attr_out.word_align;

    AST_ACK_ON_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(decode_busy_o) |-> instr_ack_o) else $error("busy fell without ack"); // R4
    AST_ACK_THEN_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
        instr_ack_o |=> (!instr_ack_o && sleep_nrdy_o)) else $error("ack not followed by execution"); // R3
    AST_LDST_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_o && store_o)) else $error("load and store together"); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o) else $error("done longer than one cycle"); // R13
    AST_DONE_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> sleep_nrdy_o) else $error("done while sleep allowed"); // R11
    AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !sleep_nrdy_o) else $error("valid accepted in done cycle"); // R12

endmodule

// File: tb/aux_cop_unit_bench.sv
module aux_cop_unit_bench;

    localparam logic [5:0] OPC = 6'h04;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        valid;
    logic [31:0] word, opa, opb;
    logic        busy, ack, gpr_wr, need_ra, need_rb, priv, ovf_en, carry_en, cr_en;
    logic [2:0]  cr_field;
    logic        load, store, ea_upd, xb, xh, walign;
    logic [31:0] result;
    logic        done, sleep_nrdy;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    aux_cop_unit u_aux_cop_unit (
        .clk(clk), .rst_n(rst_n), .instr_valid_i(valid), .instr_word_i(word),
        .op_a_i(opa), .op_b_i(opb), .decode_busy_o(busy), .instr_ack_o(ack),
        .gpr_wr_o(gpr_wr), .need_ra_o(need_ra), .need_rb_o(need_rb), .priv_o(priv),
        .ovf_en_o(ovf_en), .carry_en_o(carry_en), .cr_en_o(cr_en), .cr_field_o(cr_field),
        .load_o(load), .store_o(store), .ea_update_o(ea_upd), .xfer_byte_o(xb),
        .xfer_half_o(xh), .word_align_o(walign), .result_o(result), .done_o(done),
        .sleep_nrdy_o(sleep_nrdy)
    );

    function automatic logic [15:0] attrs();
        return {gpr_wr, need_ra, need_rb, priv, ovf_en, carry_en, cr_en, cr_field,
                load, store, ea_upd, xb, xh, walign};
    endfunction

    // expected attribute vector per R5/R6, same bit order as attrs()
    function automatic logic [15:0] exp_attr(input logic [2:0] sub, input logic [2:0] crf);
        logic [15:0] v = '0;
        case (sub)
            3'd0: v = 16'b1110_1100_0000_0000;
            3'd1: v = {7'b1110_001, crf, 6'b0};
            3'd2: v = 16'b1110_0000_0000_0000;
            3'd3: v = 16'b0111_0000_0001_0011;
            3'd4: v = 16'b1100_0000_0010_1100;
            3'd5: v = 16'b0001_0000_0000_0000;
            default: v = '0;
        endcase
        return v;
    endfunction

    function automatic logic [31:0] mk(input logic [5:0] p, input logic [2:0] crf, input logic [2:0] sub);
        return {p, crf, 20'h0, sub};
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // offers a word in the current cycle, then scrambles the inputs (R2)
    task automatic issue(input logic [31:0] w, input logic [31:0] a, input logic [31:0] b);
        valid = 1'b1; word = w; opa = a; opb = b;
        tick();
        valid = 1'b0; word = ~w; opa = a ^ 32'h5a5a_1234; opb = b + 32'h0000_0777;
    endtask

    task automatic run_flow(input string req, input int lat, input int ex,
                            input logic [31:0] res, input logic [15:0] at, input bit poke);
        for (int c = 1; c <= lat; c++) begin
            chk(req, "busy", 32'(busy), 32'(c < lat));
            chk(req, "ack", 32'(ack), 32'(c == lat));
            chk("R5", "attrs", 32'(attrs()), (c == lat) ? 32'(at) : 32'h0);
            chk("R11", "sleep in decode", 32'(sleep_nrdy), 32'h1);
            if (poke && c == 1) begin valid = 1'b1; word = mk(OPC, 3'd0, 3'd1); end
            tick();
            valid = 1'b0;
        end
        for (int e = 1; e <= ex; e++) begin
            chk(req, "done", 32'(done), 32'(e == ex));
            chk(req, "result", result, (e == ex) ? res : 32'h0);
            chk("R11", "sleep in exec", 32'(sleep_nrdy), 32'h1);
            if (poke && e == ex) begin valid = 1'b1; word = mk(OPC, 3'd0, 3'd0); end
            tick();
            valid = 1'b0;
        end
        chk("R13", "done after pulse", 32'(done), 32'h0);
        chk("R11", "sleep after done", 32'(sleep_nrdy), 32'h0);
        chk("R12", "no ack after done", 32'(ack), 32'h0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; valid = 1'b0; word = '0; opa = '0; opb = '0;
        tick(); tick();
        chk("R1", "outputs in reset", {busy, ack, done, sleep_nrdy, 28'h0}, 32'h0);
        chk("R1", "result in reset", result, 32'h0);
        rst_n = 1'b1;
        tick();
        chk("R1", "attrs after reset", 32'(attrs()), 32'h0);
        chk("R1", "flags after reset", {busy, ack, done, sleep_nrdy, 28'h0}, 32'h0);
    endtask

    task automatic t_add();
        issue(mk(OPC, 3'd0, 3'd0), 32'hFFFF_FFFF, 32'h2);
        run_flow("R8 add wrap", 1, 1, 32'h1, exp_attr(3'd0, 3'd0), 1'b0);
        issue(mk(OPC, 3'd0, 3'd0), 32'h1234_0000, 32'h0000_5678);
        run_flow("R2 R3 add", 1, 1, 32'h1234_5678, exp_attr(3'd0, 3'd0), 1'b0);
    endtask

    task automatic t_xor();
        issue(mk(OPC, 3'd5, 3'd1), 32'hF0F0_0F0F, 32'hFFFF_0000);
        run_flow("R6 xor", 1, 1, 32'h0F0F_0F0F, exp_attr(3'd1, 3'd5), 1'b0);
    endtask

    task automatic t_mac();
        issue(mk(OPC, 3'd7, 3'd2), 32'd3, 32'd4);
        run_flow("R4 R9 mac", 3, 4, 32'd12, exp_attr(3'd2, 3'd0), 1'b0);
        issue(mk(OPC, 3'd0, 3'd2), 32'd5, 32'd6);
        run_flow("R9 mac accumulate", 3, 4, 32'd42, exp_attr(3'd2, 3'd0), 1'b0);
        issue(mk(OPC, 3'd0, 3'd5), 32'd9, 32'd9);
        run_flow("R4 R10 clear", 3, 1, 32'd0, exp_attr(3'd5, 3'd0), 1'b0);
        issue(mk(OPC, 3'd0, 3'd2), 32'd2, 32'd2);
        run_flow("R10 mac after clear", 3, 4, 32'd4, exp_attr(3'd2, 3'd0), 1'b0);
        issue(mk(OPC, 3'd0, 3'd2), 32'h0001_0000, 32'h0001_0000);
        run_flow("R9 mac truncate", 3, 4, 32'd4, exp_attr(3'd2, 3'd0), 1'b0);
    endtask

    task automatic t_mem();
        issue(mk(OPC, 3'd0, 3'd3), 32'hAAAA_AAAA, 32'h5555_5555);
        run_flow("R10 store half", 1, 1, 32'h0, exp_attr(3'd3, 3'd0), 1'b0);
        issue(mk(OPC, 3'd0, 3'd4), 32'h1111_1111, 32'h2222_2222);
        run_flow("R10 load byte", 1, 1, 32'h0, exp_attr(3'd4, 3'd0), 1'b0);
    endtask

    task automatic t_reject(input logic [31:0] w, input string what);
        issue(w, 32'd1, 32'd1);
        chk("R7", {what, " ack"}, 32'(ack), 32'h0);
        chk("R7", {what, " busy"}, 32'(busy), 32'h0);
        chk("R7", {what, " sleep"}, 32'(sleep_nrdy), 32'h1);
        tick();
        chk("R7", {what, " idle"}, {ack, done, sleep_nrdy, 29'h0}, 32'h0);
        issue(mk(OPC, 3'd0, 3'd0), 32'd7, 32'd8);
        run_flow("R7 accept after reject", 1, 1, 32'd15, exp_attr(3'd0, 3'd0), 1'b0);
    endtask

    task automatic t_ignore();
        issue(mk(OPC, 3'd0, 3'd0), 32'd100, 32'd23);
        run_flow("R12 add poked", 1, 1, 32'd123, exp_attr(3'd0, 3'd0), 1'b1);
        issue(mk(OPC, 3'd0, 3'd2), 32'd6, 32'd7);
        run_flow("R12 mac poked", 3, 4, 32'd46, exp_attr(3'd2, 3'd0), 1'b1);
        issue(mk(OPC, 3'd0, 3'd1), 32'h1, 32'h3);
        run_flow("R12 accept after done", 1, 1, 32'h2, exp_attr(3'd1, 3'd0), 1'b0);
    endtask

    initial begin
        t_reset();
        t_add();
        t_xor();
        t_mac();
        t_mem();
        t_reject(mk(6'h05, 3'd0, 3'd0), "foreign opcode");
        t_reject(mk(OPC, 3'd0, 3'd6), "sub-op 6");
        t_reject(mk(OPC, 3'd0, 3'd7), "sub-op 7");
        t_reject(mk(OPC, 3'd0, 3'd0) | 32'h0000_0100, "reserved bit");
        t_ignore();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule